// File: doc/BRIEF.md
# Power-Management Event and Timer Register Block

This block sits behind a 64-byte register window and gathers the power-management state of a system. It holds a free-running timer advanced by a clock-enable tick, a sticky event status register, an enable register and a control register. A single level-type system control interrupt (`sci`) is raised while any event that can interrupt is both pending and enabled. Status bits are cleared by writing ones to them. When any event is set in the same cycle that software clears it, the event wins, so none is lost.

Writing the control register with its suspend-enable bit set starts a sleep request. A small sequencer then issues one-cycle request pulses: `shutdown_req` for sleep type 0, and `reset_req` with `resume_mark` for sleep type 1. The sequencer has three states. `SLP_IDLE` waits for a request. `SLP_OFF` drives the shutdown pulse. `SLP_WAKE` drives the reset and resume-marker pulses. The transitions are:
- IDLE to OFF on a type-0 request.
- IDLE to WAKE on a type-1 request.
- OFF to IDLE and WAKE to IDLE unconditionally, unless a new request arrives in that cycle, in which case that request is decoded again.

A separate two-byte advanced power management port holds a command byte and a scratch byte. Command values can switch the SCI-enable control bit on or off, and any command write can raise a one-cycle SMI pulse.

Top module: `pm_evt_block`

## Requirements
- R1: After reset, every register reads zero, the timer reads zero, and `sci`, `shutdown_req`, `reset_req`, `resume_mark` and `smi_pulse` are low.
- R2: The timer advances by one on each cycle with `tick` high and wraps at 2^TMR_W. A word-size (`bus_size`=2) read at offset 0x08 returns it in bits TMR_W-1:0 with every higher bit zero.
- R3: Status bit 0 (timer overflow) sets on a tick that takes the low TMR_W-1 timer bits from all ones to zero. This is the next multiple of 2^(TMR_W-1). The bit stays set until cleared.
- R4: A half-word (`bus_size`=1) write at offset 0x00 clears each status bit written as 1 and leaves the bits written as 0. An event that sets a bit in the same cycle overrides the clear of that bit.
- R5: `sci` is high exactly while status and enable (offset 0x02, half-word) share a set bit among bits 0, 5, 8 and 10.
- R6: The power-button input sets status bit 8 only while enable bit 8 is set. Otherwise it has no effect.
- R7: A half-word write at offset 0x04 stores all control bits except bit 13, which always reads 0. Only when bit 13 is written as 1 are bits 12:10 decoded as the sleep type.
- R8: Sleep type 0 gives a one-cycle `shutdown_req` pulse in the cycle after the write.
- R9: Sleep type 1 sets status bits 15 and 8 and gives one-cycle `reset_req` and `resume_mark` pulses in the cycle after the write. Sleep types 2 to 7 produce no pulse and change no status.
- R10: An APM write at `apm_addr`=0 stores the command byte. Command 0xF1 sets control bit 0, 0xF0 clears it, and other values leave it alone. At `apm_addr`=1 the write stores a scratch byte. `apm_rdata` returns the selected byte.
- R11: Every APM command write (`apm_addr`=0) made while `smi_en` is high gives a one-cycle `smi_pulse` in the following cycle. Scratch writes and writes made with `smi_en` low give none.
- R12: Reads of undefined offsets, or of a defined offset with the wrong size, return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable |
| pwr_btn | input | 1 | Power-button event, active high per cycle |
| smi_en | input | 1 | Allows SMI pulses on APM command writes |
| bus_sel | input | 1 | Register window access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset within the window |
| bus_size | input | 2 | 0 byte, 1 half-word, 2 word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| apm_sel | input | 1 | APM port access strobe |
| apm_wr | input | 1 | APM write |
| apm_addr | input | 1 | 0 command byte, 1 scratch byte |
| apm_wdata | input | 8 | APM write data |
| apm_rdata | output | 8 | APM read data |
| sci | output | 1 | System control interrupt level |
| smi_pulse | output | 1 | SMI request pulse |
| shutdown_req | output | 1 | Soft power-off request pulse |
| reset_req | output | 1 | System reset request pulse |
| resume_mark | output | 1 | Resume-from-sleep marker pulse |

## Verification
The power button can set status bit 8 in the same cycle that software writes a one to clear that bit. The bench provokes this by driving `pwr_btn` together with a half-word status write of 0x0100, and passes only if bit 8 still reads set afterwards. The timer-overflow event and a write that clears bit 0 can coincide in the same way, and both share the one set-over-clear merge. Timer sweeps run in a configuration with an 8-bit timer, so every overflow boundary and wrap is visited and its status compared with an arithmetic model.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

    typedef enum logic [1:0] {
        SLP_IDLE = 2'd0,
        SLP_OFF  = 2'd1,
        SLP_WAKE = 2'd2
    } slp_state_t;

    localparam int WIN_AW = 6;

    localparam logic [WIN_AW-1:0] OFS_STS = 6'h00;
    localparam logic [WIN_AW-1:0] OFS_EN  = 6'h02;
    localparam logic [WIN_AW-1:0] OFS_CTL = 6'h04;
    localparam logic [WIN_AW-1:0] OFS_TMR = 6'h08;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam int BIT_TMR  = 0;
    localparam int BIT_PWR  = 8;
    localparam int BIT_SUSP = 13;
    localparam int BIT_WAKE = 15;

    localparam logic [15:0] SCI_SRC_MASK = 16'h0521;

    localparam logic [2:0] SLP_TYPE_OFF  = 3'd0;
    localparam logic [2:0] SLP_TYPE_WAKE = 3'd1;

    localparam logic [7:0] APM_SCI_ON  = 8'hF1;
    localparam logic [7:0] APM_SCI_OFF = 8'hF0;

endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [TMR_W-1:0] count,
    output logic             roll
);
    localparam int LOW_W = TMR_W - 1;

    // Boundary crossing: low bits all ones on an advancing tick.
    assign roll = tick && (&count[LOW_W-1:0]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/pm_sleep_fsm.sv
module pm_sleep_fsm
    import pm_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [2:0] slp_type,
    output logic       shutdown_req,
    output logic       reset_req,
    output logic       resume_mark
);
    slp_state_t state_q, state_d;

    always_comb begin
        state_d = SLP_IDLE;
        unique case (state_q)
            SLP_IDLE, SLP_OFF, SLP_WAKE: begin
                if (go && slp_type == SLP_TYPE_OFF) begin
                    state_d = SLP_OFF;
                end else if (go && slp_type == SLP_TYPE_WAKE) begin
                    state_d = SLP_WAKE;
                end else begin
                    state_d = SLP_IDLE;
                end
            end
            default: state_d = SLP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        shutdown_req = 1'b0;
        reset_req    = 1'b0;
        resume_mark  = 1'b0;
        unique case (state_q)
            SLP_IDLE: ;
            SLP_OFF:  shutdown_req = 1'b1;
            SLP_WAKE: begin
                reset_req   = 1'b1;
                resume_mark = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pm_apm_port.sv
module pm_apm_port
    import pm_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       wr,
    input  logic       addr,
    input  logic [7:0] wdata,
    input  logic       smi_en,
    output logic [7:0] rdata,
    output logic       smi_pulse,
    output logic       sci_on,
    output logic       sci_off
);
    logic [7:0] cmd_q;
    logic [7:0] scratch_q;
    logic       cmd_hit;

    assign cmd_hit = sel && wr && !addr;
    assign sci_on  = cmd_hit && (wdata == APM_SCI_ON);
    assign sci_off = cmd_hit && (wdata == APM_SCI_OFF);
    assign rdata   = addr ? scratch_q : cmd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            scratch_q <= '0;
            smi_pulse <= 1'b0;
        end else begin
            smi_pulse <= cmd_hit && smi_en;
            if (sel && wr) begin
                if (addr) begin
                    scratch_q <= wdata;
                end else begin
                    cmd_q <= wdata;
                end
            end
        end
    end
endmodule

// File: rtl/pm_evt_block.sv
module pm_evt_block
    import pm_evt_pkg::*;
#(
    parameter int TMR_W = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        pwr_btn,
    input  logic        smi_en,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [5:0]  bus_addr,
    input  logic [1:0]  bus_size,
    input  logic [15:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        apm_sel,
    input  logic        apm_wr,
    input  logic        apm_addr,
    input  logic [7:0]  apm_wdata,
    output logic [7:0]  apm_rdata,
    output logic        sci,
    output logic        smi_pulse,
    output logic        shutdown_req,
    output logic        reset_req,
    output logic        resume_mark
);
    localparam logic [15:0] SUSP_MASK = 16'(1) << BIT_SUSP;

    logic [TMR_W-1:0] count;
    logic             roll;
    logic [15:0]      sts_q, en_q, ctl_q;
    logic [15:0]      sts_set, sts_clr;
    logic             wr_half, sts_wr, en_wr, ctl_wr;
    logic             sleep_go, wake_evt;
    logic             apm_on, apm_off;

    pm_timer #(.TMR_W(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .count (count),
        .roll  (roll)
    );

    assign wr_half  = bus_sel && bus_wr && (bus_size == SZ_HALF);
    assign sts_wr   = wr_half && (bus_addr == OFS_STS);
    assign en_wr    = wr_half && (bus_addr == OFS_EN);
    assign ctl_wr   = wr_half && (bus_addr == OFS_CTL);
    assign sleep_go = ctl_wr && bus_wdata[BIT_SUSP];
    assign wake_evt = sleep_go && (bus_wdata[12:10] == SLP_TYPE_WAKE);

    pm_sleep_fsm u_sleep (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (sleep_go),
        .slp_type     (bus_wdata[12:10]),
        .shutdown_req (shutdown_req),
        .reset_req    (reset_req),
        .resume_mark  (resume_mark)
    );

    pm_apm_port u_apm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (apm_sel),
        .wr        (apm_wr),
        .addr      (apm_addr),
        .wdata     (apm_wdata),
        .smi_en    (smi_en),
        .rdata     (apm_rdata),
        .smi_pulse (smi_pulse),
        .sci_on    (apm_on),
        .sci_off   (apm_off)
    );

    // Event sources; set takes precedence over a same-cycle clear.
    always_comb begin
        sts_set           = '0;
        sts_set[BIT_TMR]  = roll;
        sts_set[BIT_PWR]  = (pwr_btn && en_q[BIT_PWR]) || wake_evt;
        sts_set[BIT_WAKE] = wake_evt;
        sts_clr           = sts_wr ? bus_wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
            en_q  <= '0;
            ctl_q <= '0;
        end else begin
            sts_q <= (sts_q & ~sts_clr) | sts_set;
            if (en_wr) begin
                en_q <= bus_wdata;
            end
            if (ctl_wr) begin
                ctl_q <= bus_wdata & ~SUSP_MASK;
            end
            if (apm_on) begin
                ctl_q[0] <= 1'b1;
            end else if (apm_off) begin
                ctl_q[0] <= 1'b0;
            end
        end
    end

    assign sci = |(sts_q & en_q & SCI_SRC_MASK);

    always_comb begin
        bus_rdata = '0;
        if (bus_size == SZ_HALF) begin
            case (bus_addr)
                OFS_STS: bus_rdata[15:0] = sts_q;
                OFS_EN:  bus_rdata[15:0] = en_q;
                OFS_CTL: bus_rdata[15:0] = ctl_q;
                default: bus_rdata = '0;
            endcase
        end else if (bus_size == SZ_WORD && bus_addr == OFS_TMR) begin
            bus_rdata[TMR_W-1:0] = count;
        end
    end
endmodule

// File: rtl/pm_evt_block_chk.sv
module pm_evt_block_chk
    import pm_evt_pkg::*;
#(
    parameter int TMR_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [TMR_W-1:0] count,
    input logic             sci,
    input logic [15:0]      en_q,
    input logic [15:0]      sts_q,
    input logic             shutdown_req,
    input logic             reset_req,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [5:0]       bus_addr,
    input logic [1:0]       bus_size,
    input logic [15:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             apm_sel,
    input logic             apm_wr,
    input logic             apm_addr,
    input logic             smi_en,
    input logic             smi_pulse
);
    // R2
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == $past(count) + 1'b1));

    // R5
    sci_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sci |-> (|(en_q & SCI_SRC_MASK)));

    // R7
    susp_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CTL && bus_size == SZ_HALF) |-> !bus_rdata[BIT_SUSP]);

    // R8
    sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(bus_sel && bus_wr && bus_size == SZ_HALF &&
                               bus_addr == OFS_CTL && bus_wdata[BIT_SUSP] &&
                               bus_wdata[12:10] == SLP_TYPE_OFF));

    // R9
    wake_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (sts_q[BIT_WAKE] && !shutdown_req));

    // R11
    smi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse |-> $past(apm_sel && apm_wr && !apm_addr && smi_en));
endmodule

bind pm_evt_block pm_evt_block_chk #(.TMR_W(TMR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .count        (count),
    .sci          (sci),
    .en_q         (en_q),
    .sts_q        (sts_q),
    .shutdown_req (shutdown_req),
    .reset_req    (reset_req),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_size     (bus_size),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .apm_sel      (apm_sel),
    .apm_wr       (apm_wr),
    .apm_addr     (apm_addr),
    .smi_en       (smi_en),
    .smi_pulse    (smi_pulse)
);

// File: tb/test_pm_evt_block.sv
`timescale 1ns/1ps
module test_pm_evt_block;
    localparam int TW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, pwr_btn = 1'b0, smi_en = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        apm_sel = 1'b0, apm_wr = 1'b0, apm_addr = 1'b0;
    logic [7:0]  apm_wdata = '0;
    logic [7:0]  apm_rdata;
    logic        sci, smi_pulse, shutdown_req, reset_req, resume_mark;

    int n_chk = 0;
    int n_err = 0;
    int model_t = 0;
    logic model_ov = 1'b0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    pm_evt_block #(.TMR_W(TW)) i_pm_evt_block (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_btn(pwr_btn), .smi_en(smi_en),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .apm_sel(apm_sel), .apm_wr(apm_wr), .apm_addr(apm_addr),
        .apm_wdata(apm_wdata), .apm_rdata(apm_rdata),
        .sci(sci), .smi_pulse(smi_pulse), .shutdown_req(shutdown_req),
        .reset_req(reset_req), .resume_mark(resume_mark)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [1:0] sz, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
    endtask

    task automatic apm_w(input logic a, input logic [7:0] d);
        @(negedge clk);
        apm_sel = 1'b1; apm_wr = 1'b1; apm_addr = a; apm_wdata = d;
        @(negedge clk);
        apm_sel = 1'b0; apm_wr = 1'b0;
        #1;
    endtask

    task automatic one_tick();
        @(negedge clk);
        tick = 1'b1;
        if ((model_t % 128) == 127) model_ov = 1'b1;
        model_t = (model_t + 1) % 256;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic press();
        @(negedge clk);
        pwr_btn = 1'b1;
        @(negedge clk);
        pwr_btn = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(6'h00, 2'd1, rv); chk("R1 status", rv, 0);
        rd(6'h02, 2'd1, rv); chk("R1 enable", rv, 0);
        rd(6'h04, 2'd1, rv); chk("R1 control", rv, 0);
        rd(6'h08, 2'd2, rv); chk("R1 timer", rv, 0);
        chk("R1 outputs", {27'd0, sci, smi_pulse, shutdown_req, reset_req, resume_mark}, 0);
        chk("R1 apm", {24'd0, apm_rdata}, 0);

        // R2 / R3 timer sweep across two wraps of boundaries
        for (int k = 0; k < 300; k++) begin
            one_tick();
            rd(6'h08, 2'd2, rv); chk("R2 timer value", rv, model_t);
            rd(6'h00, 2'd1, rv); chk("R3 overflow status", rv, {31'd0, model_ov});
        end

        // R4 write-one-to-clear, then R3 re-arm at next boundary
        wr(6'h00, 2'd1, 16'h0000);
        rd(6'h00, 2'd1, rv); chk("R4 zero write keeps", rv, 32'h1);
        wr(6'h00, 2'd1, 16'h0001);
        model_ov = 1'b0;
        rd(6'h00, 2'd1, rv); chk("R4 clear bit0", rv, 0);
        while ((model_t % 128) != 127) one_tick();
        rd(6'h00, 2'd1, rv); chk("R3 not yet", rv, 0);
        one_tick();
        rd(6'h00, 2'd1, rv); chk("R3 rearmed", rv, 32'h1);

        // R6 power button with enable set
        wr(6'h02, 2'd1, 16'h0100);
        press();
        rd(6'h00, 2'd1, rv); chk("R6 button sets", rv, 32'h0101);

        // R5 sweep of enable patterns; status has bits 0 and 8
        for (int p = 0; p < 32; p++) begin
            logic [15:0] e;
            e = {5'd0, p[3], 2'd0, p[2], 2'd0, p[1], 3'd0, p[4], p[0]};
            wr(6'h02, 2'd1, e);
            chk("R5 sci level", {31'd0, sci}, {31'd0, (p[0] | p[2])});
        end

        // R6 button ignored when enable bit 8 clear
        wr(6'h00, 2'd1, 16'hFFFF);
        wr(6'h02, 2'd1, 16'h0000);
        press();
        rd(6'h00, 2'd1, rv); chk("R6 button ignored", rv, 0);

        // R4 collision: button set wins over same-cycle clear
        wr(6'h02, 2'd1, 16'h0100);
        press();
        @(negedge clk);
        pwr_btn = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h00; bus_size = 2'd1; bus_wdata = 16'h0100;
        @(negedge clk);
        pwr_btn = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd(6'h00, 2'd1, rv); chk("R4 set beats clear", rv, 32'h0100);
        wr(6'h00, 2'd1, 16'h0100);
        rd(6'h00, 2'd1, rv); chk("R4 plain clear", rv, 0);
        wr(6'h02, 2'd1, 16'h0000);

        // R7 without suspend enable: no decode
        wr(6'h04, 2'd1, 16'h0000);
        chk("R7 no decode", {29'd0, shutdown_req, reset_req, resume_mark}, 0);

        // R7 / R8 / R9 sleep type sweep
        for (int t = 0; t < 8; t++) begin
            logic [15:0] v;
            v = 16'h2040 | 16'(t << 10);
            wr(6'h04, 2'd1, v);
            chk("R8 shutdown pulse", {31'd0, shutdown_req}, {31'd0, t == 0});
            chk("R9 reset pulse", {30'd0, reset_req, resume_mark}, (t == 1) ? 32'h3 : 32'h0);
            @(negedge clk); #1;
            chk("R8 R9 single cycle", {29'd0, shutdown_req, reset_req, resume_mark}, 0);
            rd(6'h04, 2'd1, rv); chk("R7 bit13 not stored", rv, {16'd0, v & 16'hDFFF});
            rd(6'h00, 2'd1, rv); chk("R9 status", rv, (t == 1) ? 32'h8100 : 32'h0);
            wr(6'h00, 2'd1, 16'hFFFF);
        end
        wr(6'h04, 2'd1, 16'h0000);

        // R10 APM command and scratch
        apm_w(1'b0, 8'hF1);
        rd(6'h04, 2'd1, rv); chk("R10 sci enable on", rv, 32'h1);
        chk("R11 no smi when disabled", {31'd0, smi_pulse}, 0);
        apm_w(1'b0, 8'h12);
        rd(6'h04, 2'd1, rv); chk("R10 other cmd no change", rv, 32'h1);
        apm_addr = 1'b0; #1 chk("R10 cmd readback", {24'd0, apm_rdata}, 32'h12);
        apm_w(1'b0, 8'hF0);
        rd(6'h04, 2'd1, rv); chk("R10 sci enable off", rv, 0);
        smi_en = 1'b1;
        apm_w(1'b1, 8'h5A);
        chk("R11 scratch no smi", {31'd0, smi_pulse}, 0);
        apm_addr = 1'b1; #1 chk("R10 scratch readback", {24'd0, apm_rdata}, 32'h5A);
        apm_addr = 1'b0; #1 chk("R10 cmd kept", {24'd0, apm_rdata}, 32'hF0);
        apm_w(1'b0, 8'h33);
        chk("R11 smi pulse", {31'd0, smi_pulse}, 32'h1);
        @(negedge clk); #1;
        chk("R11 smi one cycle", {31'd0, smi_pulse}, 0);
        smi_en = 1'b0;

        // R12 undefined offsets and sizes
        wr(6'h02, 2'd1, 16'h1234);
        wr(6'h04, 2'd1, 16'h0042);
        for (int a = 0; a < 64; a++) begin
            if (a != 0 && a != 2 && a != 4) begin
                wr(6'(a), 2'd1, 16'hFFFF);
                rd(6'(a), 2'd1, rv); chk("R12 undefined read", rv, 0);
            end
        end
        wr(6'h02, 2'd0, 16'hFFFF);
        wr(6'h08, 2'd2, 16'h00FF);
        rd(6'h02, 2'd1, rv); chk("R12 enable untouched", rv, 32'h1234);
        rd(6'h04, 2'd1, rv); chk("R12 control untouched", rv, 32'h0042);
        rd(6'h00, 2'd1, rv); chk("R12 status untouched", rv, 0);
        rd(6'h02, 2'd2, rv); chk("R12 wrong size read", rv, 0);
        rd(6'h08, 2'd1, rv); chk("R12 timer half read", rv, 0);
        rd(6'h08, 2'd2, rv); chk("R2 timer untouched", rv, model_t);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule